// File: doc/BRIEF.md
# Thermal-Budget Turbo Controller

This block decides, once per sampling tick, which of eight frequency/power levels the cores should run at. While the chip draws less than its rated power, the unused difference is banked as an energy credit. When work arrives, that credit lets the controller ask for a level whose power is above the rating. The block then lowers the request one level at a time as the bank empties, until the request settles at the highest level that stays within the rating.

Two bounds always apply. An absolute reliability ceiling caps every request, however much credit is banked. A burst timer limits how long one stretch of load may stay above the rating. The timer defaults to 25 seconds and is counted in ticks. The block does not read a temperature sensor or drive a regulator. It takes one power sample and a load flag per tick, and it returns a level number and a flag that is high while that level is above the rating.

Top module: `turbo_budget_ctrl`

## Requirements
- R1: After reset, `lvl_req` is 0, `over_limit` is 0, the credit is zero and the burst timer is clear.
- R2: On every tick, the credit changes by LIMIT minus `meas_pwr`, and the result is clamped to the range 0 to CREDIT_MAX.
- R3: On a tick with `load_active` low, the next `lvl_req` is 0 and the burst timer clears.
- R4: On a tick with `load_active` high, nonzero credit and the burst timer not expired, the allowance is LIMIT + (credit >> CREDIT_SHIFT), capped at CEIL. The next `lvl_req` is the highest level whose table power does not exceed that allowance. The default table, from level 0 up to level 7, is 20, 35, 50, 65, 80, 95, 110, 125.
- R5: On a tick with `load_active` high and zero credit, the next `lvl_req` is the sustained level, which is the highest level with power at or below LIMIT (level 4 with the defaults).
- R6: Within one continuous load period, at most BURST_SEC*TICKS_PER_SEC ticks (100 with the defaults) produce a request above LIMIT. After that, the request holds at the sustained level until `load_active` falls. A new load period re-arms the timer.
- R7: The table power of `lvl_req` never exceeds CEIL (level 6 at most with the defaults).
- R8: `over_limit` is high exactly when the table power of `lvl_req` is above LIMIT.
- R9: `lvl_req` and the credit change only on cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sampling strobe; the state advances when it is high |
| meas_pwr | input | PW | Measured power sample for this tick |
| load_active | input | 1 | High when the cores have work |
| lvl_req | output | 3 | Requested frequency/power level, 0 to 7 |
| over_limit | output | 1 | High while the requested level is above the rated limit |

## Verification
The hardest conditions to reach from the ports are the two clamp edges of the credit and the expiry of the burst timer, because the credit register cannot be read directly. The bench fills the bank by idling at zero power for more ticks than saturation needs. It then drains the bank at a known rate and counts how many ticks stay at the ceiling level; an unclamped bank would stretch that count. For the lower edge, it drives the bank below zero and then refills it by an amount that yields a different level only if the negative value was held. The timer is reached by loading at exactly the rated power, so the credit stays full and only the timer can end the burst.

// File: rtl/turbo_budget_ctrl.sv
module turbo_budget_ctrl #(
  parameter int PW            = 10,
  parameter int CW            = 12,
  parameter int LIMIT         = 80,
  parameter int CEIL          = 110,
  parameter int CREDIT_MAX    = 2000,
  parameter int CREDIT_SHIFT  = 4,
  parameter int TICKS_PER_SEC = 4,
  parameter int BURST_SEC     = 25,
  parameter logic [8*PW-1:0] LVL_PWR = {10'd125, 10'd110, 10'd95, 10'd80,
                                        10'd65,  10'd50,  10'd35, 10'd20}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [PW-1:0] meas_pwr,
  input  logic          load_active,
  output logic [2:0]    lvl_req,
  output logic          over_limit
);

  localparam int BURST_TICKS = BURST_SEC * TICKS_PER_SEC;
  localparam int BW = $clog2(BURST_TICKS + 1);
  localparam int SW = ((CW > PW) ? CW : PW) + 2;

  function automatic int pwr_of(input logic [2:0] l);
    return int'(LVL_PWR[int'(l)*PW +: PW]);
  endfunction

  function automatic logic [2:0] pick(input int allow);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 0; i < 8; i++)
      if (int'(LVL_PWR[i*PW +: PW]) <= allow) r = 3'(i);
    return r;
  endfunction

  localparam logic [2:0] SUS_LVL = pick(LIMIT);

  logic [CW-1:0]        credit_q, credit_d;
  logic [BW-1:0]        burst_q;
  logic signed [SW-1:0] sum;
  logic                 expired, boost;
  int                   raw_allow, allow;
  logic [2:0]           lvl_d;

  assign sum = $signed({{(SW-CW){1'b0}}, credit_q}) + $signed(SW'(LIMIT))
             - $signed({{(SW-PW){1'b0}}, meas_pwr});

  always_comb begin
    if (sum < 0)                             credit_d = '0;
    else if (sum > $signed(SW'(CREDIT_MAX))) credit_d = CW'(CREDIT_MAX);
    else                                     credit_d = sum[CW-1:0];
  end

  assign expired   = int'(burst_q) >= BURST_TICKS;
  assign boost     = load_active && (credit_q != '0) && !expired;
  assign raw_allow = LIMIT + int'(credit_q >> CREDIT_SHIFT);
  assign allow     = !boost ? LIMIT : ((raw_allow > CEIL) ? CEIL : raw_allow);
  assign lvl_d     = load_active ? pick(allow) : 3'd0;
  assign over_limit = pwr_of(lvl_req) > LIMIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit_q <= '0;
      burst_q  <= '0;
      lvl_req  <= 3'd0;
    end else if (tick) begin
      credit_q <= credit_d;
      lvl_req  <= lvl_d;
      if (!load_active)
        burst_q <= '0;
      else if (pwr_of(lvl_d) > LIMIT && !expired)
        burst_q <= burst_q + BW'(1);
    end
  end

  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load_active |=> lvl_req == 3'd0);

  p_zero_credit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick && load_active && credit_q == '0 |=> lvl_req == SUS_LVL);

  p_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_of(lvl_req) <= CEIL);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lvl_req) && $stable(credit_q));

  p_credit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(credit_q) <= CREDIT_MAX);

  p_burst_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(burst_q) <= BURST_TICKS);

  p_over_counted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    over_limit |-> burst_q != '0);

endmodule

// File: tb/tb_turbo_budget_ctrl.sv
module tb_turbo_budget_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [9:0] meas_pwr = '0;
  logic       load_active = 1'b0;
  logic [2:0] lvl_req;
  logic       over_limit;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  turbo_budget_ctrl dut (.clk(clk), .rst_n(rst_n), .tick(tick), .meas_pwr(meas_pwr),
                         .load_active(load_active), .lvl_req(lvl_req), .over_limit(over_limit));

  // {load, meas[9:0], expected level[2:0], expected over}
  localparam logic [14:0] VEC [12] = '{
    {1'b1, 10'd80,  3'd4, 1'b0},
    {1'b0, 10'd0,   3'd0, 1'b0},
    {1'b0, 10'd0,   3'd0, 1'b0},
    {1'b0, 10'd0,   3'd0, 1'b0},
    {1'b0, 10'd0,   3'd0, 1'b0},
    {1'b1, 10'd110, 3'd5, 1'b1},
    {1'b1, 10'd95,  3'd5, 1'b1},
    {1'b1, 10'd95,  3'd5, 1'b1},
    {1'b1, 10'd95,  3'd5, 1'b1},
    {1'b1, 10'd95,  3'd5, 1'b1},
    {1'b1, 10'd80,  3'd4, 1'b0},
    {1'b0, 10'd0,   3'd0, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic ld, input int m);
    @(negedge clk);
    load_active = ld;
    meas_pwr = 10'(m);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    load_active = 1'b0;
    tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt, mx;
    do_reset();
    check("R1 level after reset", lvl_req, 0);
    check("R1 over after reset", over_limit, 0);

    // R3 idle, R4 allowance steps, R5 zero credit, R8 flag
    for (int i = 0; i < 12; i++) begin
      step(VEC[i][14], int'(VEC[i][13:4]));
      check($sformatf("R4/R3/R5 level vec %0d", i), lvl_req, int'(VEC[i][3:1]));
      check($sformatf("R8 over vec %0d", i), over_limit, int'(VEC[i][0]));
    end

    // R9: no tick, no change even with load and credit present
    @(negedge clk);
    load_active = 1'b1;
    meas_pwr = '0;
    repeat (3) @(negedge clk);
    check("R9 level held without tick", lvl_req, 0);
    step(1'b1, 0);
    check("R9 tick then applies load", lvl_req, 5);

    // R2 lower clamp
    do_reset();
    step(1'b1, 125);
    check("R5 zero credit level", lvl_req, 4);
    repeat (3) step(1'b0, 0);
    step(1'b1, 80);
    check("R2 credit clamped at zero", lvl_req, 5);

    // R6 burst timer, R7 ceiling
    do_reset();
    repeat (30) step(1'b0, 0);
    cnt = 0; mx = 0;
    for (int i = 0; i < 105; i++) begin
      step(1'b1, 80);
      if (over_limit) cnt++;
      if (int'(lvl_req) > mx) mx = int'(lvl_req);
    end
    check("R6 boosted ticks per burst", cnt, 100);
    check("R7 highest level requested", mx, 6);
    check("R6 level after expiry", lvl_req, 4);
    step(1'b0, 80);
    check("R3 idle after burst", lvl_req, 0);
    step(1'b1, 80);
    check("R6 timer re-armed", lvl_req, 6);

    // R2 upper clamp
    do_reset();
    repeat (50) step(1'b0, 0);
    cnt = 0;
    for (int i = 0; i < 45; i++) begin
      step(1'b1, 125);
      if (lvl_req == 3'd6) cnt++;
    end
    check("R2 credit clamped at max", cnt, 34);
    check("R4 stepped down to sustained", lvl_req, 4);

    // R1 reset mid-burst
    do_reset();
    check("R1 level after second reset", lvl_req, 0);
    check("R1 over after second reset", over_limit, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule